// File: doc/BRIEF.md
# Distance-Coded Safe Control Sequencer

This block is a five-state control sequencer whose state register holds fixed 4-bit codewords. Any two legal codewords differ in at least two bit positions. A single flipped bit in the register therefore always yields a code that belongs to no legal state, and such an upset cannot move the machine silently into another valid state. All sixteen values the register can hold are decoded explicitly. Every unassigned value sends the machine to the start state on the next clock edge. While the register holds such a value, all control outputs are held low.

The machine waits in IDLE for `start`. It then passes through a single-cycle LOAD state into RUN. From RUN it alternates with WAIT on each `step`, and it leaves WAIT for DONE when `done` is seen. DONE returns to IDLE on its own. When an illegal code is observed, the block raises a one-cycle error pulse and sets a sticky error flag that only reset clears. A 3-bit debug index reports the current state.

A test hook lets a bench inject any code into the register, so that recovery from every unused code can be exercised in simulation.

Top module: `safe_seq_fsm`

## Requirements
- R1: The legal state codes are IDLE=4'b0000, LOAD=4'b0011, RUN=4'b0101, WAIT=4'b0110 and DONE=4'b1001. `state_idx` shows 0 for IDLE, 1 for LOAD, 2 for RUN, 3 for WAIT, 4 for DONE, and 7 for any other code.
- R2: Flipping any single bit of any legal code gives a code for which `state_idx` reads 7.
- R3: The state advances as follows: IDLE goes to LOAD when `start` is high and otherwise stays in IDLE; LOAD goes to RUN unconditionally; RUN goes to WAIT when `step` is high and otherwise stays in RUN; WAIT goes to DONE when `done` is high, goes to RUN when `step` is high and `done` is low, and otherwise stays in WAIT; DONE goes to IDLE unconditionally.
- R4: When the register holds an illegal code and `force_en` is low, the next clock edge loads IDLE.
- R5: Each control output is high only in its own state: `o_load` in LOAD, `o_run` in RUN, `o_hold` in WAIT and `o_done` in DONE. All four outputs are low in IDLE and low whenever the code is illegal.
- R6: `err_pulse` is high for exactly the one cycle that follows a clock edge at which the register held an illegal code. It is low at all other times.
- R7: `err_sticky` is set by the same event that raises `err_pulse` and stays high until reset.
- R8: An asynchronous active-low `rst_n` loads IDLE and clears `err_pulse` and `err_sticky`.
- R9: When `force_en` is high, the next clock edge loads `force_code` into the state register, overriding all other transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Leave IDLE |
| step | input | 1 | Toggle between RUN and WAIT |
| done | input | 1 | Finish from WAIT |
| force_en | input | 1 | Test hook: load `force_code` at the next edge |
| force_code | input | 4 | Code injected by the test hook |
| o_load | output | 1 | High in LOAD |
| o_run | output | 1 | High in RUN |
| o_hold | output | 1 | High in WAIT |
| o_done | output | 1 | High in DONE |
| err_pulse | output | 1 | One-cycle pulse after an illegal code |
| err_sticky | output | 1 | Error seen since reset |
| state_idx | output | 3 | Debug index of the current state, 7 if illegal |

## Verification
A control input or a forced code applied before a clock edge changes the state register at that edge. `state_idx` and the four control outputs follow it in the same cycle, because they are decoded from the register alone. `err_pulse` and `err_sticky` rise one edge after the illegal code was held, which is the same edge at which the register recovers to IDLE. The bench changes inputs and compares every output against its behavioural model at the falling edge, so each value is sampled half a cycle after the rising edge that produced it. Directed checks step through each forced single-bit upset and each unused code, and look at the cycle in which the code is held and at the cycle that follows.

// File: rtl/safe_seq_fsm.sv
module safe_seq_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       step,
  input  logic       done,
  input  logic       force_en,
  input  logic [3:0] force_code,
  output logic       o_load,
  output logic       o_run,
  output logic       o_hold,
  output logic       o_done,
  output logic       err_pulse,
  output logic       err_sticky,
  output logic [2:0] state_idx
);

  localparam logic [3:0] C_IDLE = 4'b0000;
  localparam logic [3:0] C_LOAD = 4'b0011;
  localparam logic [3:0] C_RUN  = 4'b0101;
  localparam logic [3:0] C_WAIT = 4'b0110;
  localparam logic [3:0] C_DONE = 4'b1001;
  localparam logic [2:0] IDX_BAD = 3'd7;

  logic [3:0] cur, nxt, decoded_nxt;
  logic       bad;

  always_comb begin
    bad         = 1'b0;
    state_idx   = IDX_BAD;
    decoded_nxt = C_IDLE;
    case (cur)
      C_IDLE: begin
        state_idx   = 3'd0;
        decoded_nxt = start ? C_LOAD : C_IDLE;
      end
      C_LOAD: begin
        state_idx   = 3'd1;
        decoded_nxt = C_RUN;
      end
      C_RUN: begin
        state_idx   = 3'd2;
        decoded_nxt = step ? C_WAIT : C_RUN;
      end
      C_WAIT: begin
        state_idx   = 3'd3;
        if (done)      decoded_nxt = C_DONE;
        else if (step) decoded_nxt = C_RUN;
        else           decoded_nxt = C_WAIT;
      end
      C_DONE: begin
        state_idx   = 3'd4;
        decoded_nxt = C_IDLE;
      end
      4'b0001, 4'b0010, 4'b0100, 4'b0111,
      4'b1000, 4'b1010, 4'b1011, 4'b1100,
      4'b1101, 4'b1110, 4'b1111: begin
        bad         = 1'b1;
        decoded_nxt = C_IDLE;
      end
      default: begin
        bad         = 1'b1;
        decoded_nxt = C_IDLE;
      end
    endcase
  end

  assign nxt = force_en ? force_code : decoded_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= C_IDLE;
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      cur        <= nxt;
      err_pulse  <= bad;
      err_sticky <= err_sticky | bad;
    end
  end

  assign o_load = (cur == C_LOAD);
  assign o_run  = (cur == C_RUN);
  assign o_hold = (cur == C_WAIT);
  assign o_done = (cur == C_DONE);

  a_r4_recover_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idx == IDX_BAD && !force_en) |=> (state_idx == 3'd0));

  a_r5_safe_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idx == IDX_BAD) |-> !(o_load || o_run || o_hold || o_done));

  a_r5_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_load, o_run, o_hold, o_done}));

  a_r6_pulse_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idx == IDX_BAD) |=> err_pulse);

  a_r6_no_pulse_when_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idx != IDX_BAD) |=> !err_pulse);

  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  a_r3_load_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (o_load && !force_en) |=> o_run);

  a_r3_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && !force_en) |=> (state_idx == 3'd0));

  a_r9_force_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && force_code == C_WAIT) |=> o_hold);

endmodule

// File: tb/safe_seq_fsm_bench.sv
`timescale 1ns/1ps
module safe_seq_fsm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, step = 0, done = 0, force_en = 0;
  logic [3:0] force_code = 4'd0;
  logic o_load, o_run, o_hold, o_done, err_pulse, err_sticky;
  logic [2:0] state_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  safe_seq_fsm u_safe_seq_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .done(done),
    .force_en(force_en), .force_code(force_code),
    .o_load(o_load), .o_run(o_run), .o_hold(o_hold), .o_done(o_done),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .state_idx(state_idx));

  // reference model
  logic [3:0] m_code;
  bit m_pulse, m_sticky;
  logic [3:0] legal [5] = '{4'b0000, 4'b0011, 4'b0101, 4'b0110, 4'b1001};

  function automatic int idx_of(logic [3:0] c);
    for (int i = 0; i < 5; i++) if (legal[i] == c) return i;
    return 7;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 4'b0000; m_pulse = 0; m_sticky = 0;
    end else begin
      int k;
      k = idx_of(m_code);
      m_pulse = (k == 7);
      if (k == 7) m_sticky = 1;
      if (force_en) m_code = force_code;
      else case (k)
        0: m_code = start ? legal[1] : legal[0];
        1: m_code = legal[2];
        2: m_code = step ? legal[3] : legal[2];
        3: m_code = done ? legal[4] : (step ? legal[2] : legal[3]);
        4: m_code = legal[0];
        default: m_code = legal[0];
      endcase
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      int k;
      k = idx_of(m_code);
      check(state_idx == 3'(k), "R3 state_idx", state_idx, k);
      check({o_load, o_run, o_hold, o_done} ==
            {k == 1, k == 2, k == 3, k == 4}, "R5 outputs",
            {o_load, o_run, o_hold, o_done}, {k == 1, k == 2, k == 3, k == 4});
      check(err_pulse == m_pulse, "R6 err_pulse", err_pulse, m_pulse);
      check(err_sticky == m_sticky, "R7 err_sticky", err_sticky, m_sticky);
    end
  end

  task automatic drive(bit s, bit st, bit d, bit fe, logic [3:0] fc);
    start = s; step = st; done = d; force_en = fe; force_code = fc;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(state_idx == 0 && !err_sticky && !err_pulse, "R8 reset state", state_idx, 0);
    // R3 normal flow
    drive(0, 1, 1, 0, 0);
    check(state_idx == 0, "R3 idle holds", state_idx, 0);
    drive(1, 0, 0, 0, 0);
    check(o_load && state_idx == 1, "R1 load idx", state_idx, 1);
    drive(0, 0, 0, 0, 0);
    check(o_run && state_idx == 2, "R3 load to run", state_idx, 2);
    drive(0, 1, 0, 0, 0);
    check(o_hold && state_idx == 3, "R3 run to wait", state_idx, 3);
    drive(0, 1, 0, 0, 0);
    check(state_idx == 2, "R3 wait to run", state_idx, 2);
    drive(0, 1, 0, 0, 0);
    drive(0, 1, 1, 0, 0);
    check(o_done && state_idx == 4, "R3 done wins over step", state_idx, 4);
    drive(0, 0, 0, 0, 0);
    check(state_idx == 0, "R3 done to idle", state_idx, 0);
    // R9 force each legal code
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 0, 1, legal[i]);
      check(state_idx == 3'(i), "R9 forced legal code / R1 index", state_idx, i);
    end
    drive(0, 0, 0, 0, 0);
    // R2 single-bit upsets
    for (int i = 0; i < 5; i++) begin
      for (int b = 0; b < 4; b++) begin
        drive(0, 0, 0, 1, legal[i] ^ (4'b1 << b));
        check(state_idx == 7, "R2 single flip illegal", state_idx, 7);
        check(!(o_load | o_run | o_hold | o_done), "R5 safe outputs", 1, 0);
        drive(1, 1, 1, 0, 0);
        check(state_idx == 0, "R4 recover to idle", state_idx, 0);
        check(err_pulse && err_sticky, "R6 pulse after illegal", err_pulse, 1);
        drive(0, 0, 0, 0, 0);
        check(!err_pulse && err_sticky, "R7 sticky stays, pulse ends", err_pulse, 0);
      end
    end
    // every code
    for (int c = 0; c < 16; c++) begin
      drive(0, 0, 0, 1, 4'(c));
      check(state_idx == 3'(idx_of(4'(c))), "R1 index of code", state_idx, idx_of(4'(c)));
    end
    // R8 reset clears sticky
    drive(0, 0, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(state_idx == 0 && !err_sticky && !err_pulse, "R8 reset clears", err_sticky, 0);
    rst_n = 1'b1;
    // random
    for (int n = 0; n < 3000; n++) begin
      bit fe;
      fe = ($urandom_range(0, 19) == 0);
      drive(1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), fe, 4'($urandom));
    end
    drive(0, 0, 0, 0, 0);
    finish_run();
  end
endmodule